// File: doc/BRIEF.md
# Direct-Mapped Block Cache Controller

This controller sits between a processor and a slower word-addressed main memory. It keeps 512 words of 12 bits as 64 lines of eight words each. Each line has one tag and one valid flag, and that pair covers all eight words in the line. A processor read whose line is present is answered from the local store without touching main memory. A read whose line is absent fetches the whole line from main memory, lowest word first, installs the new tag and then returns the requested word.

Writes always go through to main memory. The local copy changes only when the written address is already present; a write to an absent line leaves the store and all valid flags untouched. An initialise pulse drops every valid flag, so every access misses until its line has been fetched again. Two free-running counters report hits and misses so the hit ratio can be measured.

Both sides use a request/ready handshake. The processor raises `cpu_req_i` and holds its address and data until `cpu_ready_o` pulses for one cycle. The controller raises `mem_req_o` and holds address, direction and data until main memory pulses `mem_ready_i`. Only one processor request is in flight at a time.

Top module: `blkcache_ctrl`

## Requirements
- R1: The 15-bit word address is split into tag = bits 14:9, line index = bits 8:3 and word offset = bits 2:0. Main-memory fill addresses are {tag, index, word}.
- R2: A read hits when the indexed line is valid and its stored tag equals the address tag. A read hit raises `cpu_ready_o` in the cycle after the request is accepted, with the stored word on `cpu_rdata_o`, and performs no main-memory transaction.
- R3: A read miss performs exactly eight main-memory reads for words 0 to 7 of the line, in ascending order. It then returns the word at the requested offset, which is the current main-memory content.
- R4: After a fill, the line's tag is stored and its valid flag is set, so reads of any of the eight words in that line hit.
- R5: A one-cycle `init_i` pulse while the controller is idle clears every valid flag. The next read of any previously cached line misses.
- R6: Every write performs exactly one main-memory write with the request's address and data. On a hit, the cached word is also updated, and a later read hit returns the new value.
- R7: A write miss allocates no line and changes no valid flag. A later read of that address still misses.
- R8: `cpu_ready_o` is never high while `mem_req_o` is high, and it is a single-cycle pulse. While `mem_req_o` is high and `mem_ready_i` is low, `mem_addr_o` stays stable.
- R9: `hit_count_o` and `miss_count_o` reset to zero. Each accepted request (read or write) adds one to exactly one of them, according to its hit status. `init_i` does not change them.
- R10: Two addresses with the same index and different tags evict each other, so alternating reads between them miss every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Clear all valid flags (acted on when idle) |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 15 | Processor word address |
| cpu_wdata_i | input | 12 | Processor write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 12 | Read data, valid with ready |
| mem_req_o | output | 1 | Main-memory request |
| mem_we_o | output | 1 | Main-memory write strobe |
| mem_addr_o | output | 15 | Main-memory word address |
| mem_wdata_o | output | 12 | Main-memory write data |
| mem_ready_i | input | 1 | Main-memory completion pulse |
| mem_rdata_i | input | 12 | Main-memory read data, valid with ready |
| hit_count_o | output | 16 | Accesses that hit |
| miss_count_o | output | 16 | Accesses that missed |

## Verification
Two situations are hard to reach from the ports. The first is a write hit to a line whose memory image later differs from the original fill. The second is a write miss followed by a read of the same address, where a wrongly allocated line would hide the fault. The random stimulus confines addresses to four tags and eight indices, so lines are filled, hit, overwritten and evicted many times. It mixes about 30 % writes with a randomly changing memory latency. Directed steps first force a conflict eviction, a write miss to the top address and an initialise pulse between two reads of a cached line.

// File: rtl/blkcache_pkg.sv
`timescale 1ns/1ps
package blkcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } cache_state_e;
endpackage

// File: rtl/blkcache_tag_store.sv
`timescale 1ns/1ps
module blkcache_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_valid_o,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clr_i) begin
      valid_q <= '0;
    end else if (wr_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
endmodule

// File: rtl/blkcache_data_store.sv
`timescale 1ns/1ps
module blkcache_data_store #(
  parameter int WORD_W = 9,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [WORD_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << WORD_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/blkcache_counter.sv
`timescale 1ns/1ps
module blkcache_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/blkcache_ctrl.sv
`timescale 1ns/1ps
module blkcache_ctrl
  import blkcache_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WORD_W = IDX_W + OFF_W;

  // address field arithmetic
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [WORD_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[WORD_W-1:0];
  endfunction

  cache_state_e      state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [OFF_W-1:0]  fill_off_q;
  logic [DATA_W-1:0] rdata_q;

  // named events
  logic              is_idle;
  logic              accept;
  logic              lookup_hit;
  logic              fill_beat;
  logic              fill_last;
  logic              write_hit;
  logic              clr_valid;

  logic [TAG_W-1:0]  look_tag;
  logic              look_valid;
  logic [DATA_W-1:0] store_rdata;
  logic              store_we;
  logic [WORD_W-1:0] store_waddr;
  logic [DATA_W-1:0] store_wdata;

  assign is_idle    = (state_q == ST_IDLE);
  assign accept     = is_idle && cpu_req_i && !init_i;
  assign clr_valid  = is_idle && init_i;
  assign lookup_hit = look_valid && (look_tag == f_tag(cpu_addr_i));
  assign write_hit  = accept && cpu_we_i && lookup_hit;
  assign fill_beat  = (state_q == ST_FILL) && mem_ready_i;
  assign fill_last  = fill_beat && (fill_off_q == {OFF_W{1'b1}});

  blkcache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_valid),
    .rd_idx_i  (f_idx(cpu_addr_i)),
    .rd_tag_o  (look_tag),
    .rd_valid_o(look_valid),
    .wr_i      (fill_last),
    .wr_idx_i  (f_idx(req_addr_q)),
    .wr_tag_i  (f_tag(req_addr_q))
  );

  always_comb begin
    store_we    = 1'b0;
    store_waddr = f_word(cpu_addr_i);
    store_wdata = cpu_wdata_i;
    if (fill_beat) begin
      store_we    = 1'b1;
      store_waddr = {f_idx(req_addr_q), fill_off_q};
      store_wdata = mem_rdata_i;
    end else if (write_hit) begin
      store_we    = 1'b1;
    end
  end

  blkcache_data_store #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .we_i   (store_we),
    .waddr_i(store_waddr),
    .wdata_i(store_wdata),
    .raddr_i(f_word(cpu_addr_i)),
    .rdata_o(store_rdata)
  );

  blkcache_counter #(.W(CNT_W)) u_hits (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (accept && lookup_hit),
    .count_o(hit_count_o)
  );

  blkcache_counter #(.W(CNT_W)) u_misses (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (accept && !lookup_hit),
    .count_o(miss_count_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      fill_off_q  <= '0;
      rdata_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            req_addr_q  <= cpu_addr_i;
            req_wdata_q <= cpu_wdata_i;
            fill_off_q  <= '0;
            if (cpu_we_i) begin
              state_q <= ST_WRITE;
            end else if (lookup_hit) begin
              rdata_q <= store_rdata;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_ready_i) begin
            if (fill_off_q == f_off(req_addr_q)) rdata_q <= mem_rdata_i;
            if (fill_last) state_q <= ST_DONE;
            else           fill_off_q <= fill_off_q + OFF_W'(1);
          end
        end
        ST_WRITE: begin
          if (mem_ready_i) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = (state_q == ST_FILL)
                       ? {f_tag(req_addr_q), f_idx(req_addr_q), fill_off_q}
                       : req_addr_q;
  assign mem_wdata_o = req_wdata_q;
  assign cpu_ready_o = (state_q == ST_DONE);
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/blkcache_sva.sv
`timescale 1ns/1ps
module blkcache_sva #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic [CNT_W-1:0]  hit_count_o,
  input logic [CNT_W-1:0]  miss_count_o,
  input logic              accept,
  input logic              lookup_hit,
  input logic              fill_beat,
  input logic              fill_last
);
  assert_ready_outside_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready_o |-> !mem_req_o);

  assert_ready_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready_o |=> !cpu_ready_o);

  assert_mem_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_fill_starts_word0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_o) && !mem_we_o) |-> (mem_addr_o[OFF_W-1:0] == '0));

  assert_fill_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_beat && !fill_last) |=>
      (mem_req_o && !mem_we_o &&
       mem_addr_o == ($past(mem_addr_o) + {{(ADDR_W-1){1'b0}}, 1'b1})));

  assert_write_through_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == cpu_addr_i));

  assert_read_hit_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lookup_hit && !cpu_we_i) |=> (cpu_ready_o && !mem_req_o));

  assert_one_counter_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count_o != $past(hit_count_o)) |-> $stable(miss_count_o));
endmodule

bind blkcache_ctrl blkcache_sva #(
  .ADDR_W(ADDR_W),
  .OFF_W (OFF_W),
  .CNT_W (CNT_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_ready_o (cpu_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .hit_count_o (hit_count_o),
  .miss_count_o(miss_count_o),
  .accept      (accept),
  .lookup_hit  (lookup_hit),
  .fill_beat   (fill_beat),
  .fill_last   (fill_last)
);

// File: tb/blkcache_ctrl_test.sv
`timescale 1ns/1ps
module blkcache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [14:0] cpu_addr_i = '0;
  logic [11:0] cpu_wdata_i = '0;
  logic        cpu_ready_o;
  logic [11:0] cpu_rdata_o;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [14:0] mem_addr_o;
  logic [11:0] mem_wdata_o;
  logic        mem_ready_i;
  logic [11:0] mem_rdata_i;
  logic [15:0] hit_count_o;
  logic [15:0] miss_count_o;

  always #2.5 clk = ~clk;

  blkcache_ctrl uut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // main memory model
  logic [11:0] mm [int];
  int          lat = 1;
  int          wait_cnt = 0;
  int          rd_total = 0;
  int          wr_total = 0;
  logic [14:0] rd_log [8];
  logic [14:0] last_waddr = '0;
  logic [11:0] last_wdata = '0;

  function automatic logic [11:0] mem_val(input int a);
    if (mm.exists(a)) return mm[a];
    return 12'((a * 37 + 5) ^ (a >> 4));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready_i <= 1'b0;
      mem_rdata_i <= '0;
      wait_cnt    <= 0;
    end else if (mem_ready_i) begin
      mem_ready_i <= 1'b0;
      wait_cnt    <= 0;
    end else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        mem_ready_i <= 1'b1;
        if (mem_we_o) begin
          mm[int'(mem_addr_o)] = mem_wdata_o;
          last_waddr = mem_addr_o;
          last_wdata = mem_wdata_o;
          wr_total++;
        end else begin
          mem_rdata_i <= mem_val(int'(mem_addr_o));
          rd_log[rd_total % 8] = mem_addr_o;
          rd_total++;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // reference line state
  bit          sh_valid [64];
  logic [5:0]  sh_tag   [64];

  function automatic logic [5:0] a_tag(input logic [14:0] a); return a >> 9; endfunction
  function automatic logic [5:0] a_idx(input logic [14:0] a); return 6'((a >> 3) & 15'h3F); endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic access(input bit we, input logic [14:0] a, input logic [11:0] d);
    bit          exp_hit;
    logic [11:0] exp_data;
    int          h0, m0, r0, w0, cyc;
    exp_hit  = sh_valid[a_idx(a)] && (sh_tag[a_idx(a)] == a_tag(a));
    exp_data = mem_val(int'(a));
    h0 = int'(hit_count_o); m0 = int'(miss_count_o);
    r0 = rd_total; w0 = wr_total;
    lat = $urandom % 4;
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cpu_ready_o && mem_req_o)
        chk(0, "R8", "ready during memory request", 1, 0);
    end while (!cpu_ready_o && cyc < 400);
    chk(cpu_ready_o, "R8", "request completes", int'(cpu_ready_o), 1);
    if (!we) chk(cpu_rdata_o == exp_data, exp_hit ? "R2" : "R3", "read data",
                 int'(cpu_rdata_o), int'(exp_data));
    cpu_req_i = 1'b0;
    chk(int'(hit_count_o) - h0 == int'(exp_hit), "R9", "hit count delta",
        int'(hit_count_o) - h0, int'(exp_hit));
    chk(int'(miss_count_o) - m0 == int'(!exp_hit), "R9", "miss count delta",
        int'(miss_count_o) - m0, int'(!exp_hit));
    if (!we && !exp_hit) begin
      chk(rd_total - r0 == 8, "R3", "fill read count", rd_total - r0, 8);
      for (int i = 0; i < 8; i++)
        chk(rd_log[i] == {a_tag(a), a_idx(a), 3'(i)}, "R1", "fill address order",
            int'(rd_log[i]), int'({a_tag(a), a_idx(a), 3'(i)}));
      sh_valid[a_idx(a)] = 1;
      sh_tag[a_idx(a)]   = a_tag(a);
    end else begin
      chk(rd_total == r0, "R2", "no memory read on hit or write", rd_total - r0, 0);
    end
    if (!we && exp_hit) chk(cyc == 1, "R2", "hit latency", cyc, 1);
    if (we) begin
      chk(wr_total - w0 == 1, "R6", "write-through count", wr_total - w0, 1);
      chk(last_waddr == a, "R6", "write-through address", int'(last_waddr), int'(a));
      chk(last_wdata == d, "R6", "write-through data", int'(last_wdata), int'(d));
    end else begin
      chk(wr_total == w0, "R6", "no memory write on read", wr_total - w0, 0);
    end
  endtask

  task automatic do_init();
    int h0, m0;
    h0 = int'(hit_count_o); m0 = int'(miss_count_o);
    @(negedge clk);
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    for (int i = 0; i < 64; i++) sh_valid[i] = 0;
    chk(int'(hit_count_o) == h0 && int'(miss_count_o) == m0, "R9", "init keeps counters",
        int'(hit_count_o) + int'(miss_count_o), h0 + m0);
  endtask

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin sh_valid[i] = 0; sh_tag[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready_o && !mem_req_o, "R8", "idle after reset", int'({cpu_ready_o, mem_req_o}), 0);
    chk(hit_count_o == 0 && miss_count_o == 0, "R9", "counters after reset",
        int'(hit_count_o) + int'(miss_count_o), 0);

    // R3/R4: cold miss, then block neighbours hit
    access(0, 15'h0000, '0);
    access(0, 15'h0007, '0);
    access(0, 15'h0005, '0);
    // R10: same index, different tag evicts
    access(0, 15'h0203, '0);
    access(0, 15'h0000, '0);
    access(0, 15'h0203, '0);
    // R6: write hit updates cached copy
    access(1, 15'h0201, 12'hABC);
    access(0, 15'h0201, '0);
    chk(cpu_rdata_o == 12'hABC, "R6", "read after write hit", int'(cpu_rdata_o), 12'hABC);
    // R7: write miss does not allocate
    access(1, 15'h7FFF, 12'h5A5);
    access(0, 15'h7FFF, '0);
    chk(cpu_rdata_o == 12'h5A5, "R7", "read after write miss", int'(cpu_rdata_o), 12'h5A5);
    // requested word is the last word of the block
    access(0, 15'h1237, '0);
    // R5: initialise forces misses
    do_init();
    access(0, 15'h1230, '0);
    access(0, 15'h0201, '0);

    // random mix, confined to 4 tags and 8 indices
    for (int n = 0; n < 500; n++) begin
      logic [14:0] a;
      a = {6'($urandom % 4), 6'($urandom % 8), 3'($urandom)};
      if (n % 97 == 50) do_init();
      if (($urandom % 10) < 3) access(1, a, 12'($urandom));
      else                     access(0, a, '0);
    end
    repeat (3) @(negedge clk);
    summary();
  end
endmodule